// File: doc/BRIEF.md
# I2C Register Access Decoder

This block sits behind an I2C slave byte engine. The engine handles SCL/SDA line timing and reports start, stop and each received byte. It also reports when a transmitted byte has been clocked out, and it takes an ACK/NACK decision for every received byte. The decoder does the rest.

The first byte after a start is the address byte. The decoder compares it with a fixed device identifier and with two strap pins, so that up to four identical devices can share one bus. The byte after the address in a write is the instruction byte. It either passes a command byte to a separate command unit or loads a register pointer. The pointer selects either the wiper register space or the nonvolatile space.

Data bytes are written at the pointer, and read bytes are served from it. The pointer advances after every data byte. It is kept across stop conditions, so a later read that sends no instruction byte continues where the last transfer ended. A write-protect input blocks every store. While the nonvolatile memory reports busy, the address byte is refused, so the host can poll until the memory is ready.

Top module: `reg_access_decoder`

## Requirements
- R1: An address byte is accepted only when bits [7:3] equal the DEV_ID parameter and bits [2:1] equal `addr_pins_i`. Bit 0 is the direction (1 = read). A mismatch is NACKed, and every later byte is NACKed and ignored until the next start.
- R2: While `nv_busy_i` is high, a matching address byte is NACKed and the transfer is dropped.
- R3: In the instruction byte, bit 7 = 1 selects command mode. The byte then appears on `cmd_byte_o` with a one-cycle `cmd_valid_o` pulse one cycle after it is received, and later bytes of that transfer are ACKed and ignored. Bit 7 = 0 loads the pointer: bit 5 selects nonvolatile space (1) or wiper space (0), and bits [4:0] give the address.
- R4: Consecutive writes in wiper space step the pointer 0..7 and then wrap to 0. Addresses 0..3 hold the four wipers. Bytes written to reserved addresses 4..7 are ACKed and discarded.
- R5: A read in wiper space returns the wiper value zero-extended to 8 bits for addresses 0..3, and 0x00 for addresses 4..7.
- R6: A write in nonvolatile space to an address below 16 raises `nv_wr_o` for one cycle, with the address on `nv_addr_o` and the byte on `nv_wdata_o`. Writes to addresses 16..31 are discarded. The pointer in this space wraps from 31 to 0.
- R7: A read in nonvolatile space returns `nv_rdata_i` for addresses 0..15, 0x00 for 16..23, and byte k of the TOL_BYTES parameter (bits [8k+7:8k]) for address 24+k.
- R8: The pointer survives a stop. A read with no instruction byte starts at the saved pointer, and each byte taken with `rd_ack_i` advances it.
- R9: A write that carries only an instruction byte, followed by a repeated start and a read address, reads from the newly loaded pointer.
- R10: While `wp_n_i` is low, no wiper changes and `nv_wr_o` stays low. Data bytes are still ACKed, reads work, and command bytes are still forwarded.
- R11: After reset all wipers hold midscale (2^(WIPER_W-1), 0x80 by default), the pointer is wiper address 0, and `ack_valid_o` and `cmd_valid_o` are low.
- R12: `ack_valid_o` pulses exactly one cycle after each `byte_valid_i`, with `ack_o` giving the decision (1 = ACK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_pins_i | input | 2 | Strapped device address bits |
| wp_n_i | input | 1 | Write enable, low = protected |
| start_i | input | 1 | Start or repeated start seen |
| stop_i | input | 1 | Stop seen |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | ACK decision strobe |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| rd_ack_i | input | 1 | Byte on tx_byte_o has been sent |
| tx_byte_o | output | 8 | Byte to transmit at the pointer |
| cmd_valid_o | output | 1 | Command byte strobe |
| cmd_byte_o | output | 8 | Forwarded command byte |
| nv_busy_i | input | 1 | Nonvolatile internal write in progress |
| nv_wr_o | output | 1 | Nonvolatile write strobe |
| nv_addr_o | output | NV_AW | Nonvolatile address (read and write) |
| nv_wdata_o | output | 8 | Nonvolatile write data |
| nv_rdata_i | input | 8 | Nonvolatile read data at nv_addr_o |
| wiper_o | output | N_WIPER*WIPER_W | Wiper registers, wiper 0 in the low bits |

## Verification
The hardest state to reach is a pointer that has wrapped or crossed into a reserved or read-only region and is then used by a different transfer, after a stop. The outcome depends on the history of several earlier transactions.

The stimulus reaches this state by mixing random writes, current-address reads and dummy-write random reads that start at random addresses across both spaces and run for random lengths. A bench model carries the pointer from one transaction to the next. Directed runs pin down the exact 7-to-0 wrap, the step from 15 into the discard area, and the read-only bytes, with and without write protect.

// File: rtl/reg_dec_pkg.sv
`timescale 1ns/1ps
package reg_dec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA, ST_CMD, ST_DROP
  } dec_state_t;

  // pointer step: nonvolatile space wraps at 32, wiper space at 2**span_bits
  function automatic logic [4:0] ptr_step(input logic nv, input logic [4:0] p,
                                          input int span_bits);
    logic [4:0] mask;
    mask = 5'((1 << span_bits) - 1);
    return nv ? 5'(p + 5'd1) : (5'(p + 5'd1) & mask);
  endfunction
endpackage

// File: rtl/dev_addr_match.sv
`timescale 1ns/1ps
module dev_addr_match #(
  parameter logic [4:0] DEV_ID = 5'b01011
) (
  input  logic [7:0] byte_i,
  input  logic [1:0] pins_i,
  output logic       hit_o,
  output logic       rd_o
);
  assign hit_o = (byte_i[7:3] == DEV_ID) && (byte_i[2:1] == pins_i);
  assign rd_o  = byte_i[0];
endmodule

// File: rtl/reg_ptr.sv
`timescale 1ns/1ps
module reg_ptr #(
  parameter int SPAN_BITS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       load_nv_i,
  input  logic [4:0] load_addr_i,
  input  logic       advance_i,
  output logic [4:0] ptr_o,
  output logic       nv_o
);
  import reg_dec_pkg::*;
  logic [4:0] ptr_q;
  logic       nv_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      nv_q  <= 1'b0;
    end else if (load_i) begin
      ptr_q <= load_addr_i;
      nv_q  <= load_nv_i;
    end else if (advance_i) begin
      ptr_q <= ptr_step(nv_q, ptr_q, SPAN_BITS);
    end
  end

  assign ptr_o = ptr_q;
  assign nv_o  = nv_q;

  a_r4_wiper_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i && !nv_q && ptr_q == 5'((1 << SPAN_BITS) - 1)) |=> (ptr_q == 5'd0));
  a_r6_nv_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i && nv_q && ptr_q == 5'd31) |=> (ptr_q == 5'd0));
endmodule

// File: rtl/rd_mux.sv
`timescale 1ns/1ps
module rd_mux #(
  parameter int          N_WIPER   = 4,
  parameter int          WIPER_W   = 8,
  parameter int          NV_DEPTH  = 16,
  parameter logic [63:0] TOL_BYTES = 64'h0
) (
  input  logic                         nv_i,
  input  logic [4:0]                   ptr_i,
  input  logic [N_WIPER*WIPER_W-1:0]   wipers_i,
  input  logic [7:0]                   nv_rdata_i,
  output logic [7:0]                   data_o
);
  localparam int         WSEL = (N_WIPER > 1) ? $clog2(N_WIPER) : 1;
  localparam logic [4:0] NW   = 5'(N_WIPER);
  localparam logic [4:0] NVD  = 5'(NV_DEPTH);

  logic [WSEL-1:0]    sel;
  logic [WIPER_W-1:0] wsel_val;

  assign sel      = ptr_i[WSEL-1:0];
  assign wsel_val = wipers_i[sel*WIPER_W +: WIPER_W];

  always_comb begin
    data_o = 8'h00;
    if (nv_i) begin
      if (ptr_i[4:3] == 2'b11) data_o = TOL_BYTES[{ptr_i[2:0], 3'b000} +: 8];
      else if (ptr_i < NVD)    data_o = nv_rdata_i;
    end else if (ptr_i < NW) begin
      data_o = 8'(wsel_val);
    end
  end
endmodule

// File: rtl/reg_access_decoder.sv
`timescale 1ns/1ps
module reg_access_decoder #(
  parameter logic [4:0]  DEV_ID    = 5'b01011,
  parameter int          N_WIPER   = 4,
  parameter int          WIPER_W   = 8,
  parameter int          SPAN_BITS = 3,
  parameter int          NV_DEPTH  = 16,
  parameter int          NV_AW     = $clog2(NV_DEPTH),
  parameter logic [63:0] TOL_BYTES = 64'h7F00_A233_0180_0F1C
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 addr_pins_i,
  input  logic                       wp_n_i,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic                       byte_valid_i,
  input  logic [7:0]                 byte_i,
  output logic                       ack_valid_o,
  output logic                       ack_o,
  input  logic                       rd_ack_i,
  output logic [7:0]                 tx_byte_o,
  output logic                       cmd_valid_o,
  output logic [7:0]                 cmd_byte_o,
  input  logic                       nv_busy_i,
  output logic                       nv_wr_o,
  output logic [NV_AW-1:0]           nv_addr_o,
  output logic [7:0]                 nv_wdata_o,
  input  logic [7:0]                 nv_rdata_i,
  output logic [N_WIPER*WIPER_W-1:0] wiper_o
);
  import reg_dec_pkg::*;
  localparam logic [4:0]         NW   = 5'(N_WIPER);
  localparam logic [4:0]         NVD  = 5'(NV_DEPTH);
  localparam logic [WIPER_W-1:0] MIDV = WIPER_W'(1 << (WIPER_W - 1));

  dec_state_t state_q, state_d;
  logic addr_hit, addr_rd;
  logic [4:0] ptr;
  logic ptr_nv;
  logic ack_valid_q, ack_q, ack_d, cmd_valid_q;
  logic [7:0] cmd_byte_q;
  logic [N_WIPER*WIPER_W-1:0] wiper_q;

  // named internal events
  logic ev_addr, ev_accept, ev_instr, ev_wdata, ev_rdata, ev_load, wiper_wr;
  assign ev_addr   = byte_valid_i && state_q == ST_ADDR;
  assign ev_accept = ev_addr && addr_hit && !nv_busy_i;
  assign ev_instr  = byte_valid_i && state_q == ST_INSTR;
  assign ev_wdata  = byte_valid_i && state_q == ST_WDATA;
  assign ev_rdata  = rd_ack_i && state_q == ST_RDATA;
  assign ev_load   = ev_instr && !byte_i[7];
  assign wiper_wr  = ev_wdata && !ptr_nv && wp_n_i && (ptr < NW);

  dev_addr_match #(.DEV_ID(DEV_ID)) u_match (
    .byte_i(byte_i), .pins_i(addr_pins_i), .hit_o(addr_hit), .rd_o(addr_rd));

  reg_ptr #(.SPAN_BITS(SPAN_BITS)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ev_load), .load_nv_i(byte_i[5]),
    .load_addr_i(byte_i[4:0]), .advance_i(ev_wdata || ev_rdata),
    .ptr_o(ptr), .nv_o(ptr_nv));

  rd_mux #(.N_WIPER(N_WIPER), .WIPER_W(WIPER_W), .NV_DEPTH(NV_DEPTH),
           .TOL_BYTES(TOL_BYTES)) u_rd (
    .nv_i(ptr_nv), .ptr_i(ptr), .wipers_i(wiper_q), .nv_rdata_i(nv_rdata_i),
    .data_o(tx_byte_o));

  always_comb begin
    state_d = state_q;
    if (start_i) state_d = ST_ADDR;
    else if (stop_i) state_d = ST_IDLE;
    else if (byte_valid_i) begin
      case (state_q)
        ST_ADDR:  state_d = ev_accept ? (addr_rd ? ST_RDATA : ST_INSTR) : ST_DROP;
        ST_INSTR: state_d = byte_i[7] ? ST_CMD : ST_WDATA;
        default:  state_d = state_q;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_ADDR:                    ack_d = addr_hit && !nv_busy_i;
      ST_INSTR, ST_WDATA, ST_CMD: ack_d = 1'b1;
      default:                    ack_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ack_valid_q <= 1'b0;
      ack_q       <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_byte_q  <= 8'h00;
    end else begin
      state_q     <= state_d;
      ack_valid_q <= byte_valid_i;
      ack_q       <= byte_valid_i && ack_d;
      cmd_valid_q <= ev_instr && byte_i[7];
      if (ev_instr && byte_i[7]) cmd_byte_q <= byte_i;
    end
  end

  for (genvar gi = 0; gi < N_WIPER; gi++) begin : g_wiper
    always_ff @(posedge clk_i) begin
      if (!rst_ni) wiper_q[gi*WIPER_W +: WIPER_W] <= MIDV;
      else if (wiper_wr && ptr == 5'(gi))
        wiper_q[gi*WIPER_W +: WIPER_W] <= byte_i[WIPER_W-1:0];
    end
  end

  assign ack_valid_o = ack_valid_q;
  assign ack_o       = ack_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_byte_o  = cmd_byte_q;
  assign nv_wr_o     = ev_wdata && ptr_nv && wp_n_i && (ptr < NVD);
  assign nv_addr_o   = ptr[NV_AW-1:0];
  assign nv_wdata_o  = byte_i;
  assign wiper_o     = wiper_q;

  a_r12_ack_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(byte_valid_i));
  a_r2_busy_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_addr && !start_i && nv_busy_i) |=> (ack_valid_o && !ack_o));
  a_r1_mismatch_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_addr && !addr_hit) |=> !ack_o);
  a_r10_wp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_n_i |=> $stable(wiper_o));
  a_r5_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_nv && ptr >= NW) |-> (tx_byte_o == 8'h00));
endmodule

// File: tb/tb_reg_access_decoder.sv
`timescale 1ns/1ps
module tb_reg_access_decoder;
  localparam logic [4:0]  DEVID = 5'b01011;
  localparam logic [63:0] TOL   = 64'h7F00_A233_0180_0F1C;
  localparam logic [1:0]  PINS  = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pins = PINS;
  logic wp_n = 1'b1, start = 1'b0, stop = 1'b0, bv = 1'b0, rdack = 1'b0, busy = 1'b0;
  logic [7:0] byt = 8'h00;
  logic ack_valid, ack, cmd_valid, nv_wr;
  logic [7:0] tx, cmd_byte, nv_wdata, nv_rdata;
  logic [3:0] nv_addr;
  logic [31:0] wiper;

  always #2.5 clk = ~clk;

  reg_access_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_pins_i(pins), .wp_n_i(wp_n),
    .start_i(start), .stop_i(stop), .byte_valid_i(bv), .byte_i(byt),
    .ack_valid_o(ack_valid), .ack_o(ack), .rd_ack_i(rdack), .tx_byte_o(tx),
    .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte), .nv_busy_i(busy),
    .nv_wr_o(nv_wr), .nv_addr_o(nv_addr), .nv_wdata_o(nv_wdata),
    .nv_rdata_i(nv_rdata), .wiper_o(wiper));

  // nonvolatile storage serving the design
  logic [7:0] nv_mem [16];
  int nv_wr_cnt = 0;
  assign nv_rdata = nv_mem[nv_addr];
  always @(posedge clk) if (nv_wr) begin nv_mem[nv_addr] <= nv_wdata; nv_wr_cnt <= nv_wr_cnt + 1; end

  // bench model
  logic [7:0] m_w [4];
  logic [7:0] m_nv [16];
  logic [4:0] m_p;
  logic       m_nv_sel;
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [4:0] m_next(input logic s, input logic [4:0] p);
    return s ? 5'((p + 1) % 32) : 5'((p + 1) % 8);
  endfunction

  function automatic logic [7:0] m_read(input logic s, input logic [4:0] p);
    if (!s) return (p < 4) ? m_w[p[1:0]] : 8'h00;
    if (p >= 24) return TOL[(p - 24) * 8 +: 8];
    if (p >= 16) return 8'h00;
    return m_nv[p[3:0]];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic do_stop();
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask
  task automatic send(input logic [7:0] b, output logic a, output logic v);
    @(negedge clk); bv = 1'b1; byt = b;
    @(negedge clk); bv = 1'b0; v = ack_valid; a = ack;
  endtask
  task automatic recv(output logic [7:0] d);
    @(negedge clk); d = tx; rdack = 1'b1;
    @(negedge clk); rdack = 1'b0;
  endtask

  function automatic logic [31:0] m_wipers();
    return {m_w[3], m_w[2], m_w[1], m_w[0]};
  endfunction

  // write transfer: address, instruction, data bytes; model updated
  task automatic wr_xfer(input logic s, input logic [4:0] a, input int n, input string req);
    logic ak, v;
    logic [7:0] d;
    do_start();
    send({DEVID, PINS, 1'b0}, ak, v); chk({req, " addr ack"}, ak, 1);
    send({2'b00, s, a}, ak, v); chk({req, " instr ack"}, ak, 1);
    m_p = a; m_nv_sel = s;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send(d, ak, v); chk({req, " data ack"}, ak, 1);
      if (wp_n) begin
        if (!s && m_p < 4) m_w[m_p[1:0]] = d;
        if (s && m_p < 16) m_nv[m_p[3:0]] = d;
      end
      m_p = m_next(m_nv_sel, m_p);
    end
    do_stop();
  endtask

  task automatic rd_bytes(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv(d); chk(req, d, m_read(m_nv_sel, m_p));
      m_p = m_next(m_nv_sel, m_p);
    end
  endtask

  task automatic cur_read(input int n, input string req);
    logic ak, v;
    do_start();
    send({DEVID, PINS, 1'b1}, ak, v); chk({req, " raddr ack"}, ak, 1);
    rd_bytes(n, req);
    do_stop();
  endtask

  task automatic rand_read(input logic s, input logic [4:0] a, input int n, input string req);
    logic ak, v;
    do_start();
    send({DEVID, PINS, 1'b0}, ak, v); chk({req, " addr ack"}, ak, 1);
    send({2'b00, s, a}, ak, v); chk({req, " instr ack"}, ak, 1);
    m_p = a; m_nv_sel = s;
    do_start();
    send({DEVID, PINS, 1'b1}, ak, v); chk({req, " raddr ack"}, ak, 1);
    rd_bytes(n, req);
    do_stop();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ak, v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin nv_mem[i] = 8'(i * 7 + 3); m_nv[i] = 8'(i * 7 + 3); end
    for (int i = 0; i < 4; i++) m_w[i] = 8'h80;
    m_p = 0; m_nv_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 wipers midscale", wiper, 32'h8080_8080);
    chk("R11 ack idle", ack_valid, 0);
    chk("R11 cmd idle", cmd_valid, 0);
    chk("R11 pointer 0", tx, 8'h80);

    // R1 wrong pins
    do_start();
    send({DEVID, 2'b01, 1'b0}, ak, v);
    chk("R12 ack strobe", v, 1);
    chk("R1 pin mismatch nack", ak, 0);
    send(8'h01, ak, v); chk("R1 dropped byte nack", ak, 0);
    send(8'h55, ak, v); chk("R1 dropped data nack", ak, 0);
    do_stop();
    chk("R1 no wiper change", wiper, m_wipers());

    // R4 consecutive wiper write with wrap: 2,3,4..7 discarded, 0
    wr_xfer(1'b0, 5'd2, 7, "R4");
    chk("R4 wrap and reserved discard", wiper, m_wipers());
    // R8 current read continues from retained pointer (now 1)
    cur_read(3, "R8 current read");
    cur_read(4, "R5 reserved read zero");

    // R2 busy polling
    busy = 1'b1;
    do_start(); send({DEVID, PINS, 1'b0}, ak, v); chk("R2 busy nack", ak, 0);
    send(8'h01, ak, v); chk("R2 dropped after busy", ak, 0);
    do_stop();
    busy = 1'b0;
    do_start(); send({DEVID, PINS, 1'b0}, ak, v); chk("R2 ready ack", ak, 1);
    do_stop();

    // R6 nonvolatile write 14,15,16(discard)
    begin
      int c0;
      c0 = nv_wr_cnt;
      wr_xfer(1'b1, 5'd14, 3, "R6");
      chk("R6 nv write count", 32'(nv_wr_cnt - c0), 2);
    end
    rand_read(1'b1, 5'd14, 3, "R9 R7 random nv read");
    rand_read(1'b1, 5'd24, 9, "R7 tolerance read");

    // R10 write protect
    wp_n = 1'b0;
    begin
      int c0;
      c0 = nv_wr_cnt;
      wr_xfer(1'b0, 5'd0, 4, "R10 wiper");
      chk("R10 wipers held", wiper, m_wipers());
      wr_xfer(1'b1, 5'd3, 2, "R10 nv");
      chk("R10 no nv write", 32'(nv_wr_cnt - c0), 0);
      rand_read(1'b1, 5'd3, 2, "R10 read under wp");
    end
    // R3 command forwarded even under protection
    do_start();
    send({DEVID, PINS, 1'b0}, ak, v);
    send(8'h87, ak, v);
    chk("R3 cmd ack", ak, 1);
    chk("R3 cmd strobe", cmd_valid, 1);
    chk("R3 cmd byte", cmd_byte, 8'h87);
    send(8'h21, ak, v);
    chk("R3 extra byte ack", ak, 1);
    chk("R3 extra byte not forwarded", cmd_valid, 0);
    do_stop();
    chk("R3 pointer untouched", wiper, m_wipers());
    cur_read(2, "R3 R8 pointer kept after cmd");
    wp_n = 1'b1;

    // random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      op = $urandom_range(0, 3);
      wp_n = ($urandom_range(0, 3) != 0);
      case (op)
        0: wr_xfer(1'b0, 5'($urandom_range(0, 7)), $urandom_range(1, 9), "R4 rnd");
        1: wr_xfer(1'b1, 5'($urandom_range(0, 31)), $urandom_range(1, 6), "R6 rnd");
        2: cur_read($urandom_range(1, 6), "R8 rnd");
        default: rand_read(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
                           $urandom_range(1, 6), "R9 rnd");
      endcase
      chk("R10 R4 rnd wipers", wiper, m_wipers());
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule